// File: doc/BRIEF.md
# Differential Clock Stop Controller

This block drives a set of buffered differential clock pairs and stops and restarts them cleanly in response to a stop request. The request can arrive at any time with no relation to the clock. An internal phase generator divides the reference clock into the output clock. Each output pair has a true leg and a complement leg. Each leg carries a level and a drive-enable flag, and a cleared drive-enable flag means that leg is tri-stated. The analog current drive is represented only by these enable flags.

The request first passes through a synchronizer. It is then sampled once per output period, at the rising edge of the complement leg. A new request level is accepted only when two consecutive samples agree. A strap input selects whether the request is active high or active low. Only outputs whose stoppable bit is set respond to an accepted request. Such an output finishes its current phase and parks at a clean edge. On release it resumes at a clean edge.

The park-mode bit selects one of two parked states. In the first, the true leg is held high and driven. In the second, both legs are held low and undriven. The output-enable input tri-states every leg of every pair at once, and it overrides everything else.

Top module: `clkstop_ctrl`

## Requirements
- R1: The effective request is the raw request XOR the strap. With the strap at 0 a raw 1 requests a stop; with the strap at 1 a raw 0 requests a stop. The opposite level leaves the outputs running.
- R2: A request level is accepted only when two consecutive complement-rising samples of the synchronized request agree. A request pulse shorter than one output period never stops an output.
- R3: An output whose stoppable bit is 0 keeps toggling normally while a stop is accepted.
- R4: No driven leg ever shows a level shorter than HALF_CYCLES reference cycles. This holds through stop, park and restart.
- R5: With park mode 0, a stopped pair holds its true leg at 1 and driven. Its complement leg is 0 and not driven.
- R6: With park mode 1, a stopped pair holds both legs at 0 and neither leg is driven.
- R7: While the output-enable input is 0, every drive-enable output is 0 in the same cycle. This holds whatever the strap, park mode or stop state.
- R8: A running pair drives both legs. The two legs are always opposite, and each leg changes level every HALF_CYCLES reference cycles.
- R9: While reset is asserted, every drive-enable output is 0.
- R10: A stoppable output parks within 8*HALF_CYCLES+4 reference cycles after the request becomes active. It resumes running within the same bound after the request is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_req_i | input | 1 | Raw stop request, asynchronous |
| stop_inv_i | input | 1 | Polarity strap: 0 = request active high, 1 = active low |
| oe_i | input | 1 | Output enable; 0 tri-states every leg |
| park_float_i | input | 1 | Park mode: 0 = true leg driven high, 1 = both legs low and undriven |
| stoppable_i | input | NUM_OUT | Per-pair stoppable bit |
| clk_t_o | output | NUM_OUT | True leg level per pair |
| clk_c_o | output | NUM_OUT | Complement leg level per pair |
| clk_t_en_o | output | NUM_OUT | True leg drive enable per pair |
| clk_c_en_o | output | NUM_OUT | Complement leg drive enable per pair |

## Verification
The stop function is tried with a stoppable mask that mixes stopping and free-running pairs. This separates per-output selection from a global halt. The request is driven at both polarities under both strap values. This shows that the strap, and not the raw level, decides the stop. Both park modes are used, which tells apart the driven-high parked state and the floating-low one. A one-cycle request glitch tells the two-sample qualification apart from a bare synchronizer. The output enable is dropped both while running and while parked to show that it overrides either state. A pulse-width monitor runs throughout and would catch a clipped phase at park or restart.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_PARK = 1'b1
  } leg_state_e;

  typedef struct packed {
    logic t_val;
    logic c_val;
    logic t_en;
    logic c_en;
  } pair_drive_t;

endpackage

// File: rtl/clkstop_rst_sync.sv
`timescale 1ns/1ps
module clkstop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/clkstop_phase.sv
`timescale 1ns/1ps
module clkstop_phase #(
  parameter int HALF_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic edge_o,
  output logic phase_next_o,
  output logic comp_rise_o
);

  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;
  logic          tick;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (tick) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  // At a tick the true phase flips; when it leaves 1 the complement rises.
  assign edge_o       = tick;
  assign phase_next_o = ~ph_q;
  assign comp_rise_o  = tick & ph_q;

endmodule

// File: rtl/clkstop_qual.sv
`timescale 1ns/1ps
module clkstop_qual #(
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic inv_i,
  input  logic sample_en_i,
  output logic accepted_o
);

  logic [SYNC_STAGES-1:0]  sync_q, sync_d;
  logic [QUAL_SAMPLES-1:0] hist_q, hist_d;
  logic                    acc_q, acc_d;
  logic                    req_act;
  logic                    agree;

  assign req_act = sync_q[SYNC_STAGES-1] ^ inv_i;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], raw_i};
    hist_d = hist_q;
    acc_d  = acc_q;
    agree  = 1'b0;
    if (sample_en_i) begin
      hist_d = {hist_q[QUAL_SAMPLES-2:0], req_act};
      agree  = (&hist_d) | ~(|hist_d);
      if (agree) begin
        acc_d = hist_d[0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      hist_q <= '0;
      acc_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
      acc_q  <= acc_d;
    end
  end

  assign accepted_o = acc_q;

endmodule

// File: rtl/clkstop_pair.sv
`timescale 1ns/1ps
module clkstop_pair
  import clkstop_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        edge_i,
  input  logic        phase_next_i,
  input  logic        halt_i,
  input  logic        park_float_i,
  output pair_drive_t drive_o
);

  localparam pair_drive_t RESET_DRV = '{t_val: 1'b0, c_val: 1'b1, t_en: 1'b0, c_en: 1'b0};

  leg_state_e  st_q, st_d;
  pair_drive_t drv_q, drv_d;

  function automatic pair_drive_t park_drive(input logic fl);
    if (fl) begin
      return '{t_val: 1'b0, c_val: 1'b0, t_en: 1'b0, c_en: 1'b0};
    end
    return '{t_val: 1'b1, c_val: 1'b0, t_en: 1'b1, c_en: 1'b0};
  endfunction

  function automatic pair_drive_t run_drive(input logic ph);
    return '{t_val: ph, c_val: ~ph, t_en: 1'b1, c_en: 1'b1};
  endfunction

  // Park only on the edge where the true leg would rise, restart only on the
  // edge where it would fall: every surviving phase keeps its full width.
  always_comb begin
    st_d  = st_q;
    drv_d = drv_q;
    if (edge_i) begin
      case (st_q)
        ST_RUN: begin
          if (halt_i && phase_next_i) begin
            st_d  = ST_PARK;
            drv_d = park_drive(park_float_i);
          end else begin
            drv_d = run_drive(phase_next_i);
          end
        end
        ST_PARK: begin
          if (!halt_i && !phase_next_i) begin
            st_d  = ST_RUN;
            drv_d = run_drive(1'b0);
          end else begin
            drv_d = park_drive(park_float_i);
          end
        end
        default: begin
          st_d  = ST_RUN;
          drv_d = RESET_DRV;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      drv_q <= RESET_DRV;
    end else begin
      st_q  <= st_d;
      drv_q <= drv_d;
    end
  end

  assign drive_o = drv_q;

endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int NUM_OUT      = 4,
  parameter int HALF_CYCLES  = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2,
  parameter int RST_STAGES   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stop_req_i,
  input  logic               stop_inv_i,
  input  logic               oe_i,
  input  logic               park_float_i,
  input  logic [NUM_OUT-1:0] stoppable_i,
  output logic [NUM_OUT-1:0] clk_t_o,
  output logic [NUM_OUT-1:0] clk_c_o,
  output logic [NUM_OUT-1:0] clk_t_en_o,
  output logic [NUM_OUT-1:0] clk_c_en_o
);

  logic        rst_n_int;
  logic        tick;
  logic        phase_next;
  logic        comp_rise;
  logic        stop_acc;
  pair_drive_t drv [NUM_OUT];

  clkstop_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  clkstop_phase #(.HALF_CYCLES(HALF_CYCLES)) u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_int),
    .edge_o       (tick),
    .phase_next_o (phase_next),
    .comp_rise_o  (comp_rise)
  );

  clkstop_qual #(
    .SYNC_STAGES  (SYNC_STAGES),
    .QUAL_SAMPLES (QUAL_SAMPLES)
  ) u_qual (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .raw_i       (stop_req_i),
    .inv_i       (stop_inv_i),
    .sample_en_i (comp_rise),
    .accepted_o  (stop_acc)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_pair
    clkstop_pair u_pair (
      .clk_i        (clk_i),
      .rst_ni       (rst_n_int),
      .edge_i       (tick),
      .phase_next_i (phase_next),
      .halt_i       (stop_acc & stoppable_i[g]),
      .park_float_i (park_float_i),
      .drive_o      (drv[g])
    );
    assign clk_t_o[g]    = drv[g].t_val;
    assign clk_c_o[g]    = drv[g].c_val;
    assign clk_t_en_o[g] = drv[g].t_en & oe_i;
    assign clk_c_en_o[g] = drv[g].c_en & oe_i;
  end

endmodule

// File: rtl/clkstop_ctrl_chk.sv
`timescale 1ns/1ps
module clkstop_ctrl_chk #(
  parameter int NUM_OUT     = 4,
  parameter int HALF_CYCLES = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               oe_i,
  input logic [NUM_OUT-1:0] clk_t_o,
  input logic [NUM_OUT-1:0] clk_c_o,
  input logic [NUM_OUT-1:0] clk_t_en_o,
  input logic [NUM_OUT-1:0] clk_c_en_o
);

  localparam int RW = $clog2(HALF_CYCLES + 1) + 1;
  localparam logic [RW-1:0] MINRUN = RW'(HALF_CYCLES);
  localparam logic [RW-1:0] CAP    = {RW{1'b1}};

  p_oe_tristate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (clk_t_en_o == '0 && clk_c_en_o == '0));

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_leg
    logic          t_last, c_last, te_last, ce_last;
    logic [RW-1:0] t_run, c_run;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        t_last <= 1'b0; c_last <= 1'b0; te_last <= 1'b0; ce_last <= 1'b0;
        t_run  <= '0;   c_run  <= '0;
      end else begin
        t_last  <= clk_t_o[i];
        c_last  <= clk_c_o[i];
        te_last <= clk_t_en_o[i];
        ce_last <= clk_c_en_o[i];
        if (!clk_t_en_o[i])           t_run <= '0;
        else if (clk_t_o[i] != t_last) t_run <= te_last ? RW'(1) : '0;
        else if (t_run != '0 && t_run != CAP) t_run <= t_run + 1'b1;
        if (!clk_c_en_o[i])           c_run <= '0;
        else if (clk_c_o[i] != c_last) c_run <= ce_last ? RW'(1) : '0;
        else if (c_run != '0 && c_run != CAP) c_run <= c_run + 1'b1;
      end
    end

    p_no_runt_true_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_t_en_o[i] && te_last && clk_t_o[i] != t_last && t_run != '0) |-> (t_run >= MINRUN));

    p_no_runt_comp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_c_en_o[i] && ce_last && clk_c_o[i] != c_last && c_run != '0) |-> (c_run >= MINRUN));

    p_legs_opposed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_t_en_o[i] && clk_c_en_o[i]) |-> (clk_t_o[i] != clk_c_o[i]));

    p_park_true_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_t_en_o[i] && !clk_c_en_o[i]) |-> clk_t_o[i]);
  end

endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
  .NUM_OUT     (NUM_OUT),
  .HALF_CYCLES (HALF_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .oe_i       (oe_i),
  .clk_t_o    (clk_t_o),
  .clk_c_o    (clk_c_o),
  .clk_t_en_o (clk_t_en_o),
  .clk_c_en_o (clk_c_en_o)
);

// File: tb/clkstop_ctrl_bench.sv
`timescale 1ns/1ps
module clkstop_ctrl_bench;

  localparam int N    = 4;
  localparam int HALF = 2;
  localparam int BOUND = 8 * HALF + 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req, inv, oe, pfl;
  logic [N-1:0] stp;
  logic [N-1:0] t_o, c_o, te_o, ce_o;

  int n_checks = 0;
  int n_err    = 0;
  int runts    = 0;

  always #2 clk = ~clk;

  clkstop_ctrl #(.NUM_OUT(N), .HALF_CYCLES(HALF)) u_clkstop_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .stop_req_i   (req),
    .stop_inv_i   (inv),
    .oe_i         (oe),
    .park_float_i (pfl),
    .stoppable_i  (stp),
    .clk_t_o      (t_o),
    .clk_c_o      (c_o),
    .clk_t_en_o   (te_o),
    .clk_c_en_o   (ce_o)
  );

  // Independent pulse-width monitor for R4
  logic [N-1:0] lt, lc, lte, lce;
  int rt [N];
  int rc [N];
  always @(negedge clk) begin
    if (!rst_n) begin
      lt = '0; lc = '0; lte = '0; lce = '0;
      for (int i = 0; i < N; i++) begin rt[i] = 0; rc[i] = 0; end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (te_o[i] && lte[i] && t_o[i] != lt[i] && rt[i] != 0 && rt[i] < HALF) runts++;
        if (!te_o[i]) rt[i] = 0;
        else if (t_o[i] != lt[i]) rt[i] = lte[i] ? 1 : 0;
        else if (rt[i] != 0 && rt[i] < 1000) rt[i]++;
        if (ce_o[i] && lce[i] && c_o[i] != lc[i] && rc[i] != 0 && rc[i] < HALF) runts++;
        if (!ce_o[i]) rc[i] = 0;
        else if (c_o[i] != lc[i]) rc[i] = lce[i] ? 1 : 0;
        else if (rc[i] != 0 && rc[i] < 1000) rc[i]++;
        lt[i] = t_o[i]; lc[i] = c_o[i]; lte[i] = te_o[i]; lce[i] = ce_o[i];
      end
    end
  end

  task automatic check_eq(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic count_changes(input int idx, input int n, output int cnt);
    logic prev;
    cnt = 0;
    @(negedge clk);
    prev = t_o[idx];
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (t_o[idx] != prev) cnt++;
      prev = t_o[idx];
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = 1'b0; inv = 1'b0; oe = 1'b1; pfl = 1'b0; stp = '1;
    wait_neg(4);
    check_eq("R9 true enables in reset", int'(te_o), 0);
    check_eq("R9 comp enables in reset", int'(ce_o), 0);
    rst_n = 1'b1;
    wait_neg(12);
  endtask

  task automatic t_running();
    int cnt;
    check_eq("R8 all true legs driven", int'(te_o), (1 << N) - 1);
    check_eq("R8 all comp legs driven", int'(ce_o), (1 << N) - 1);
    check_eq("R8 legs opposed", int'(t_o ^ c_o), (1 << N) - 1);
    count_changes(0, 8 * HALF, cnt);
    check_eq("R8 toggle rate", cnt, 8);
  endtask

  task automatic t_stop(input logic s_inv, input logic s_pfl);
    int cnt;
    inv = s_inv; req = s_inv; pfl = s_pfl; stp = 4'b0101; oe = 1'b1;
    wait_neg(3 * BOUND);
    check_eq("R1 inactive level keeps pair 0 true driven", int'(te_o[0]), 1);
    check_eq("R1 inactive level keeps pair 0 comp driven", int'(ce_o[0]), 1);
    oe = 1'b0;
    #1;
    check_eq("R7 oe low while running, true", int'(te_o), 0);
    check_eq("R7 oe low while running, comp", int'(ce_o), 0);
    @(negedge clk);
    oe = 1'b1;
    req = ~s_inv;
    wait_neg(BOUND);
    if (!s_pfl) begin
      check_eq("R5 R10 R1 parked true level", int'(t_o[0]), 1);
      check_eq("R5 parked true driven", int'(te_o[0]), 1);
      check_eq("R5 parked comp undriven", int'(ce_o[0]), 0);
      check_eq("R5 pair 2 parked", int'({t_o[2], te_o[2], ce_o[2]}), 3'b110);
    end else begin
      check_eq("R6 R10 R1 parked levels low", int'({t_o[0], c_o[0]}), 0);
      check_eq("R6 parked both undriven", int'({te_o[0], ce_o[0]}), 0);
      check_eq("R6 pair 2 parked", int'({t_o[2], c_o[2], te_o[2], ce_o[2]}), 0);
    end
    count_changes(1, 8 * HALF, cnt);
    check_eq("R3 non-stoppable pair 1 toggles", cnt, 8);
    check_eq("R3 non-stoppable pair 3 driven", int'({te_o[3], ce_o[3]}), 3);
    oe = 1'b0;
    #1;
    check_eq("R7 oe low while parked, true", int'(te_o), 0);
    check_eq("R7 oe low while parked, comp", int'(ce_o), 0);
    @(negedge clk);
    oe = 1'b1;
    req = s_inv;
    wait_neg(BOUND);
    check_eq("R10 resumed pair 0 driven", int'({te_o[0], ce_o[0]}), 3);
    count_changes(0, 8 * HALF, cnt);
    check_eq("R10 resumed pair 0 toggles", cnt, 8);
    check_eq("R4 no short pulse", runts, 0);
  endtask

  task automatic t_glitch();
    int bad = 0;
    inv = 1'b0; req = 1'b0; pfl = 1'b1; stp = '1; oe = 1'b1;
    wait_neg(3 * BOUND);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 2 * BOUND; k++) begin
      @(negedge clk);
      if (!te_o[0] || !ce_o[0]) bad++;
    end
    check_eq("R2 one-cycle request ignored", bad, 0);
  endtask

  initial begin
    t_reset();
    t_running();
    t_stop(1'b0, 1'b0);
    t_stop(1'b0, 1'b1);
    t_stop(1'b1, 1'b0);
    t_stop(1'b1, 1'b1);
    t_glitch();
    check_eq("R4 no short pulse overall", runts, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule